// File: doc/BRIEF.md
# Stall Protection Hold Timer

This block guards a brushless motor drive against a rotor that never reaches its commanded speed. It watches the in-lock flag produced by the speed control loop. While the motor is commanded to run and the flag reports that speed is outside the lock window, it counts ticks of a slow protection clock. If the out-of-lock condition lasts for a programmable number of ticks, it latches a fault, and the fault drives an inhibit signal that switches off every high-side driver.

The fault does not clear when the motor regains lock. It clears only when the motor is commanded to stop, or through reset. A static strap input switches the protection off entirely. This is how a board would tie the timing node to ground. The slow clock comes from a separate RC oscillator and arrives here as a single-cycle tick enable in the system clock domain. The hold count is set in ticks. At a 35 Hz tick, 158 ticks is about 4.5 s and 108 ticks is about 3.1 s.

Top module: `stall_guard`

## Requirements
- R1: After reset, `fault_latched` and `hs_inhibit` are both 0.
- R2: With `run_cmd`=1, `guard_off`=0 and `lock_ok`=0, the HOLD_TICKS-th cycle with `slow_tick`=1 sets `fault_latched` to 1 at the clock edge that samples that tick.
- R3: With the same conditions, HOLD_TICKS-1 ticks leave `fault_latched` at 0.
- R4: A cycle with `lock_ok`=1 before expiry resets the running count to zero, so that a further HOLD_TICKS out-of-lock ticks are needed to trip.
- R5: Cycles with `slow_tick`=0 do not advance the count, however many of them there are.
- R6: Once set, `fault_latched` stays at 1 while `run_cmd`=1, whatever `lock_ok`, `slow_tick` and `guard_off` do.
- R7: `run_cmd`=0 clears `fault_latched` at the next clock edge and holds the count at zero. After a restart, a full HOLD_TICKS ticks are needed to trip.
- R8: While `guard_off`=1 the count is held at zero and no fault is set. After the strap is released, a full HOLD_TICKS ticks are needed to trip.
- R9: `hs_inhibit` is 1 exactly when `fault_latched` is 1.
- R10: Ticks that arrive while `lock_ok`=1 are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slow_tick | input | 1 | One-cycle enable per protection clock period |
| lock_ok | input | 1 | 1 = motor speed inside the lock window |
| run_cmd | input | 1 | 1 = run, 0 = stop |
| guard_off | input | 1 | 1 = protection disabled (strap) |
| fault_latched | output | 1 | Stall fault latch |
| hs_inhibit | output | 1 | 1 = turn off all high-side drivers |

## Verification
A qualifying tick that completes the hold count shows up on `fault_latched` and `hs_inhibit` right after the same clock edge that samples it. No extra pipeline stage sits on the path. A stop command clears the latch at the very next edge. The bench changes inputs on the falling edge. It samples outputs at the following falling edge, half a cycle after the register has updated. For each number of ticks swept from zero to the hold count, it computes the expected latch value as "ticks counted since the last clear are at least the hold count". It gives the design a small hold count so that every count value is reached.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

  // Operating mode of the guard, decoded from the run command, the strap
  // and the latch state. Only GM_WATCH lets the timer advance.
  typedef enum logic [1:0] {
    GM_IDLE    = 2'd0,
    GM_WATCH   = 2'd1,
    GM_TRIPPED = 2'd2,
    GM_BYPASS  = 2'd3
  } guard_mode_e;

endpackage

// File: rtl/stall_guard_mode.sv
module stall_guard_mode
  import stall_guard_pkg::*;
(
  input  logic        run_cmd,
  input  logic        guard_off,
  input  logic        fault_q,
  output guard_mode_e mode
);

  // Stop has priority, then an already latched fault, then the strap.
  always_comb begin
    if (!run_cmd) begin
      mode = GM_IDLE;
    end else if (fault_q) begin
      mode = GM_TRIPPED;
    end else if (guard_off) begin
      mode = GM_BYPASS;
    end else begin
      mode = GM_WATCH;
    end
  end

endmodule

// File: rtl/stall_guard_timer.sv
module stall_guard_timer
  import stall_guard_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 158
) (
  input  logic        clk,
  input  logic        rst_n,
  input  guard_mode_e mode,
  input  logic        slow_tick,
  input  logic        lock_ok,
  output logic        expire
);

  localparam int unsigned CW   = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] TOP  = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          clear;
  logic          cnt_en;

  assign clear  = (mode != GM_WATCH) || lock_ok;
  assign cnt_en = clear || (slow_tick && (cnt_q != TOP));

  // The tick that completes the hold window raises expire in its own cycle.
  assign expire = (mode == GM_WATCH) && !lock_ok && slow_tick && (cnt_q == LAST);

  always_comb begin
    if (clear) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/stall_guard_latch.sv
module stall_guard_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic run_cmd,
  input  logic expire,
  output logic fault_q,
  output logic hs_inhibit
);

  logic fault_d;

  // Only a stop command (or reset) releases the latch.
  always_comb begin
    if (!run_cmd) begin
      fault_d = 1'b0;
    end else begin
      fault_d = fault_q | expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
    end
  end

  assign hs_inhibit = fault_q;

endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_guard_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 158
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic lock_ok,
  input  logic run_cmd,
  input  logic guard_off,
  output logic fault_latched,
  output logic hs_inhibit
);

  guard_mode_e mode;
  logic        expire;
  logic        fault_q;

  stall_guard_mode u_mode (
    .run_cmd   (run_cmd),
    .guard_off (guard_off),
    .fault_q   (fault_q),
    .mode      (mode)
  );

  stall_guard_timer #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .slow_tick (slow_tick),
    .lock_ok   (lock_ok),
    .expire    (expire)
  );

  stall_guard_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_cmd    (run_cmd),
    .expire     (expire),
    .fault_q    (fault_q),
    .hs_inhibit (hs_inhibit)
  );

  assign fault_latched = fault_q;

endmodule

// File: rtl/stall_guard_chk.sv
module stall_guard_chk #(
  parameter int unsigned HOLD_TICKS = 158
) (
  input logic clk,
  input logic rst_n,
  input logic slow_tick,
  input logic lock_ok,
  input logic run_cmd,
  input logic guard_off,
  input logic fault_latched,
  input logic hs_inhibit
);

  // Independent count of qualifying ticks since the last clear.
  int unsigned seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 0;
    end else if (!run_cmd || guard_off || lock_ok || fault_latched) begin
      seen_q <= 0;
    end else if (slow_tick && seen_q < HOLD_TICKS) begin
      seen_q <= seen_q + 1;
    end
  end

  AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> ($past(seen_q) == HOLD_TICKS - 1)); // R3

  AST_TRIP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past(slow_tick && !lock_ok && run_cmd)); // R2

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && run_cmd) |=> fault_latched); // R6

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_cmd |=> !fault_latched); // R7

  AST_STRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_off && !fault_latched) |=> !fault_latched); // R8

  AST_INHIBIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hs_inhibit == fault_latched); // R9

endmodule

bind stall_guard stall_guard_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .slow_tick     (slow_tick),
  .lock_ok       (lock_ok),
  .run_cmd       (run_cmd),
  .guard_off     (guard_off),
  .fault_latched (fault_latched),
  .hs_inhibit    (hs_inhibit)
);

// File: tb/stall_guard_test.sv
module stall_guard_test;

  localparam int HOLD = 4;

  logic clk;
  logic rst_n;
  logic slow_tick;
  logic lock_ok;
  logic run_cmd;
  logic guard_off;
  logic fault_latched;
  logic hs_inhibit;

  int n_cmp;
  int n_bad;
  bit done;

  stall_guard #(.HOLD_TICKS(HOLD)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .slow_tick     (slow_tick),
    .lock_ok       (lock_ok),
    .run_cmd       (run_cmd),
    .guard_off     (guard_off),
    .fault_latched (fault_latched),
    .hs_inhibit    (hs_inhibit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Each tick lasts one cycle, followed by gap idle cycles; all driving on negedge.
  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic stop_restart();
    run_cmd = 1'b0;
    @(negedge clk);
    chk("R7 stop clears", fault_latched, 1'b0);
    run_cmd = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; slow_tick = 1'b0; lock_ok = 1'b0; run_cmd = 1'b0; guard_off = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 fault reset", fault_latched, 1'b0);
    chk("R1 inhibit reset", hs_inhibit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmd = 1'b1;
    @(negedge clk);

    // Sweep tick counts 0..HOLD+1 with several gap lengths (R2, R3, R5, R9).
    for (int gap = 0; gap < 3; gap++) begin
      for (int n = 0; n <= HOLD + 1; n++) begin
        stop_restart();
        ticks(n, gap);
        repeat (6) @(negedge clk);
        chk((n >= HOLD) ? "R2 trip" : "R3 no trip / R5 idle", fault_latched, logic'(n >= HOLD));
        chk("R9 inhibit", hs_inhibit, logic'(n >= HOLD));
      end
    end

    // Exact edge: fault visible right after the sampling edge of the last tick (R2).
    stop_restart();
    ticks(HOLD - 1, 1);
    slow_tick = 1'b1;
    @(posedge clk);
    #1 slow_tick = 1'b0;
    @(negedge clk);
    chk("R2 same-edge trip", fault_latched, 1'b1);

    // R6: stays latched through lock, ticks and strap.
    lock_ok = 1'b1; guard_off = 1'b1;
    ticks(HOLD + 2, 1);
    chk("R6 sticky", fault_latched, 1'b1);
    lock_ok = 1'b0; guard_off = 1'b0;
    ticks(2, 0);
    chk("R6 sticky", fault_latched, 1'b1);

    // R7: stop mid-count resets the count.
    stop_restart();
    ticks(HOLD - 1, 0);
    stop_restart();
    ticks(HOLD - 1, 0);
    @(negedge clk);
    chk("R7 count cleared", fault_latched, 1'b0);
    ticks(1, 0);
    chk("R7 full count trips", fault_latched, 1'b1);

    // R4: brief lock restarts the window.
    stop_restart();
    ticks(HOLD - 1, 1);
    lock_ok = 1'b1;
    @(negedge clk);
    lock_ok = 1'b0;
    ticks(HOLD - 1, 1);
    chk("R4 lock clears", fault_latched, 1'b0);
    ticks(1, 0);
    chk("R4 trip after full window", fault_latched, 1'b1);

    // R10: ticks in lock are ignored.
    stop_restart();
    lock_ok = 1'b1;
    ticks(HOLD + 2, 0);
    chk("R10 in-lock ticks ignored", fault_latched, 1'b0);
    lock_ok = 1'b0;
    ticks(HOLD - 1, 0);
    chk("R10 count from zero", fault_latched, 1'b0);
    ticks(1, 0);
    chk("R10 trip", fault_latched, 1'b1);

    // R8: strap disables protection and holds count at zero.
    stop_restart();
    ticks(HOLD - 1, 0);
    guard_off = 1'b1;
    ticks(3 * HOLD, 1);
    chk("R8 strap no trip", fault_latched, 1'b0);
    chk("R8 strap no inhibit", hs_inhibit, 1'b0);
    guard_off = 1'b0;
    @(negedge clk);
    ticks(HOLD - 1, 0);
    chk("R8 count held at zero", fault_latched, 1'b0);
    ticks(1, 0);
    chk("R8 trip after release", fault_latched, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule